// File: doc/BRIEF.md
# Split-Resolution Dual PWM DAC Driver

This block turns one 12-bit sample into two 6-bit pulse-width outputs that run from a single shared counter. The high output carries the upper six bits of the sample and the low output carries the lower six bits. Both outputs have the same 64-clock period and start each period on the same edge. Off chip, the two pins are summed through resistors weighted 64:1 and then low-pass filtered. The result is an effective 12-bit level while the PWM rate stays at the 6-bit rate (about 1.95 MHz from a 125 MHz clock).

A new sample is presented with a one-cycle load strobe and is stored in a shadow register. The two duty values are held together in one packed compare word. That word moves from the shadow into the active register as a unit, and only at the moment the counter returns to zero, so a period never mixes an old half with a new half. When the enable is low, the counter stays at zero, both pins are low, and any waiting sample is taken into the active register at once.

Top module: `dpwm_split_dac`

## Requirements
- R1: While `en` is high, the shared 6-bit counter advances by one each clock and wraps from 63 to 0, which gives a period of 64 clocks.
- R2: `pwm_hi` is high exactly while the counter is below the active upper compare value. That value is sample bits [11:6].
- R3: `pwm_lo` is high exactly while the counter is below the active lower compare value. That value is sample bits [5:0].
- R4: A compare value of 0 keeps its output low for the whole period. A compare value of 63 gives 63 high clocks out of 64. Neither output is high in the clock where the counter is 63.
- R5: A sample written with `load` goes only into the shadow register. The active compare word takes the whole shadow word on the edge where the counter goes from 63 to 0, or on any edge while `en` is low. At no other time does either half change.
- R6: While `en` is low, both outputs are low and the counter is held at 0. After `en` rises, the first period starts at count 0.
- R7: After a synchronous reset (`rst` high), both outputs are low and the shadow and active compare words are zero.
- R8: `cmp_word` shows the active packed word. The upper compare value sits in bits [21:16], the lower compare value sits in bits [5:0], and every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, the counter is held at 0 and the outputs are low |
| load | input | 1 | One-cycle strobe that captures `sample` into the shadow register |
| sample | input | 12 | Sample to be converted |
| pwm_hi | output | 1 | PWM output for the upper six bits |
| pwm_lo | output | 1 | PWM output for the lower six bits |
| cmp_word | output | 22 | Active packed compare word |

## Verification
The hardest case to reach is a load that lands in the middle of a period, or in the very cycle of the wrap. In that case the old duty values must finish their period untouched, and the new pair must appear together only at the next count 0. The bench waits 130 clocks between loads in its sweep, so each load lands two counter steps later than the previous one and loads fall across every phase of the period. A reference model that tracks the shadow and active words in the bench then checks each cycle. Separate runs cover the edge values 0 and 63 in each half, and a load made while `en` is low.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   localparam int unsigned DEF_CH_BITS = 6;
   localparam int unsigned DEF_HI_LSB  = 16;

   typedef enum logic [0:0] {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
   parameter int unsigned CH_BITS = dpwm_pkg::DEF_CH_BITS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   output logic [CH_BITS-1:0] cnt,
   output logic               xfer
);
   localparam logic [CH_BITS-1:0] CNT_MAX = '1;

   // next count will be zero: held, or wrapping
   assign xfer = !en || (cnt == CNT_MAX);

   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (!en) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dpwm_cmp_buf.sv
module dpwm_cmp_buf #(
   parameter int unsigned CH_BITS = dpwm_pkg::DEF_CH_BITS,
   parameter int unsigned HI_LSB  = dpwm_pkg::DEF_HI_LSB,
   localparam int unsigned SMP_W  = 2 * CH_BITS,
   localparam int unsigned WORD_W = HI_LSB + CH_BITS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [SMP_W-1:0]   sample,
   input  logic               xfer,
   output logic [WORD_W-1:0]  act_word,
   output logic [CH_BITS-1:0] act_hi,
   output logic [CH_BITS-1:0] act_lo
);
   logic [WORD_W-1:0] shadow_word;
   logic [WORD_W-1:0] packed_in;

   always_comb begin
      packed_in = '0;
      packed_in[HI_LSB +: CH_BITS] = sample[CH_BITS +: CH_BITS];
      packed_in[0 +: CH_BITS]      = sample[0 +: CH_BITS];
   end

   always_ff @(posedge clk) begin
      if (rst)       shadow_word <= '0;
      else if (load) shadow_word <= packed_in;
   end

   always_ff @(posedge clk) begin
      if (rst)       act_word <= '0;
      else if (xfer) act_word <= shadow_word;
   end

   assign act_hi = act_word[HI_LSB +: CH_BITS];
   assign act_lo = act_word[0 +: CH_BITS];
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
   parameter int unsigned        CH_BITS  = dpwm_pkg::DEF_CH_BITS,
   parameter dpwm_pkg::out_mode_e OUT_MODE = dpwm_pkg::OUT_COMB
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [CH_BITS-1:0] cnt,
   input  logic [CH_BITS-1:0] cmp,
   output logic               pwm
);
   logic level;
   assign level = en && (cnt < cmp);

   generate
      if (OUT_MODE == dpwm_pkg::OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) pwm <= 1'b0;
            else     pwm <= level;
         end
      end else begin : g_comb
         assign pwm = level;
      end
   endgenerate
endmodule

// File: rtl/dpwm_split_dac.sv
module dpwm_split_dac #(
   parameter int unsigned         CH_BITS  = dpwm_pkg::DEF_CH_BITS,
   parameter int unsigned         HI_LSB   = dpwm_pkg::DEF_HI_LSB,
   parameter dpwm_pkg::out_mode_e OUT_MODE = dpwm_pkg::OUT_COMB,
   localparam int unsigned        SMP_W    = 2 * CH_BITS,
   localparam int unsigned        WORD_W   = HI_LSB + CH_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              load,
   input  logic [SMP_W-1:0]  sample,
   output logic              pwm_hi,
   output logic              pwm_lo,
   output logic [WORD_W-1:0] cmp_word
);
   generate
      if (CH_BITS < 1 || CH_BITS > 16) begin : g_bad_bits
         $error("dpwm_split_dac: CH_BITS out of range");
      end
      if (HI_LSB < CH_BITS) begin : g_bad_lsb
         $error("dpwm_split_dac: HI_LSB overlaps the lower field");
      end
   endgenerate

   logic [CH_BITS-1:0] cnt;
   logic               xfer;
   logic [CH_BITS-1:0] act_hi;
   logic [CH_BITS-1:0] act_lo;
   logic [CH_BITS-1:0] cmp_sel [2];
   logic [1:0]         pwm_v;

   dpwm_counter #(.CH_BITS(CH_BITS)) u_cnt (
      .clk(clk), .rst(rst), .en(en), .cnt(cnt), .xfer(xfer)
   );

   dpwm_cmp_buf #(.CH_BITS(CH_BITS), .HI_LSB(HI_LSB)) u_buf (
      .clk(clk), .rst(rst), .load(load), .sample(sample), .xfer(xfer),
      .act_word(cmp_word), .act_hi(act_hi), .act_lo(act_lo)
   );

   assign cmp_sel[0] = act_lo;
   assign cmp_sel[1] = act_hi;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_ch
         dpwm_channel #(.CH_BITS(CH_BITS), .OUT_MODE(OUT_MODE)) u_ch (
            .clk(clk), .rst(rst), .en(en), .cnt(cnt),
            .cmp(cmp_sel[i]), .pwm(pwm_v[i])
         );
      end
   endgenerate

   assign pwm_lo = pwm_v[0];
   assign pwm_hi = pwm_v[1];
endmodule

// File: rtl/dpwm_split_dac_chk.sv
module dpwm_split_dac_chk #(
   parameter int unsigned CH_BITS = 6,
   parameter int unsigned HI_LSB  = 16,
   localparam int unsigned WORD_W = HI_LSB + CH_BITS
) (
   input logic               clk,
   input logic               rst,
   input logic               en,
   input logic               pwm_hi,
   input logic               pwm_lo,
   input logic [WORD_W-1:0]  cmp_word,
   input logic [CH_BITS-1:0] cnt
);
   localparam logic [CH_BITS-1:0] CMAX = '1;
   logic [WORD_W-1:0] pad_mask;
   always_comb begin
      pad_mask = '1;
      pad_mask[HI_LSB +: CH_BITS] = '0;
      pad_mask[0 +: CH_BITS]      = '0;
   end

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      en |=> (cnt == $past(cnt) + 1'b1));
   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> (cnt == '0));
   // R6
   dis_low_chk: assert property (@(posedge clk) disable iff (rst)
      !en |-> (!pwm_hi && !pwm_lo));
   // R5
   word_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |-> $stable(cmp_word));
   // R4
   top_low_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt == CMAX) |-> (!pwm_hi && !pwm_lo));
   // R2
   hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cmp_word[HI_LSB +: CH_BITS] == '0) |-> !pwm_hi);
   // R3
   lo_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cmp_word[0 +: CH_BITS] == '0) |-> !pwm_lo);
   // R8
   pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ((cmp_word & pad_mask) == '0));
endmodule

bind dpwm_split_dac dpwm_split_dac_chk #(.CH_BITS(CH_BITS), .HI_LSB(HI_LSB)) u_chk (
   .clk(clk), .rst(rst), .en(en), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
   .cmp_word(cmp_word), .cnt(cnt)
);

// File: tb/tb_dpwm_split_dac.sv
module tb_dpwm_split_dac;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic        load = 1'b0;
   logic [11:0] sample = '0;
   logic        pwm_hi, pwm_lo;
   logic [21:0] cmp_word;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   dpwm_split_dac dut (
      .clk(clk), .rst(rst), .en(en), .load(load), .sample(sample),
      .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .cmp_word(cmp_word)
   );

   always #4 clk = ~clk;

   // reference model built from the requirements
   logic [5:0] m_cnt, m_sh_hi, m_sh_lo, m_ac_hi, m_ac_lo;
   always @(posedge clk) begin
      if (rst) begin
         m_cnt <= 0; m_sh_hi <= 0; m_sh_lo <= 0; m_ac_hi <= 0; m_ac_lo <= 0;
      end else begin
         if (load) begin m_sh_hi <= sample[11:6]; m_sh_lo <= sample[5:0]; end
         if (!en || m_cnt == 6'd63) begin m_ac_hi <= m_sh_hi; m_ac_lo <= m_sh_lo; end
         m_cnt <= en ? m_cnt + 6'd1 : 6'd0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   int acc_hi = 0, acc_lo = 0;
   always @(negedge clk) begin
      if (!rst && !done) begin
         check("R2 pwm_hi level", pwm_hi, en && (m_cnt < m_ac_hi));
         check("R3 pwm_lo level", pwm_lo, en && (m_cnt < m_ac_lo));
         check("R5/R8 cmp_word", cmp_word, {m_ac_hi, 10'd0, m_ac_lo});
         if (!en) check("R6 disabled outputs", {pwm_hi, pwm_lo}, 0);
         if (en) begin
            if (m_cnt == 0) begin acc_hi = 0; acc_lo = 0; end
            acc_hi += pwm_hi; acc_lo += pwm_lo;
            if (m_cnt == 6'd63) begin
               check("R1/R4 hi duty per period", acc_hi, m_ac_hi);
               check("R1/R4 lo duty per period", acc_lo, m_ac_lo);
            end
         end
      end
   end

   task automatic put(input logic [11:0] v);
      @(posedge clk); #1;
      sample = v; load = 1'b1;
      @(posedge clk); #1;
      load = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(3);
      // R7: reset state
      n_chk++; if (pwm_hi || pwm_lo || cmp_word != 0) begin
         n_fail++; $display("FAIL R7 reset outputs actual=%0d expected=0", {pwm_hi, pwm_lo, cmp_word});
      end
      rst = 1'b0;
      idle(2);
      check("R7 word after reset", cmp_word, 0);
      en = 1'b1;
      // sweep every value of each half; spacing of 130 moves load phase
      for (int i = 0; i < 64; i++) begin
         put({i[5:0], 6'((i * 37 + 5) % 64)});
         idle(128);
      end
      // boundary patterns for R4
      put(12'h000); idle(140);
      put(12'hFFF); idle(140);
      put(12'hFC0); idle(140);
      put(12'h03F); idle(140);
      // R5: burst of loads within one period, only the last lands
      put(12'h555); put(12'hAAA); put(12'h7E1);
      idle(140);
      // R6: disable, load while held, enable again
      en = 1'b0; idle(5);
      check("R6 disabled pins", {pwm_hi, pwm_lo}, 0);
      put(12'h842); idle(4);
      check("R5 load while disabled", cmp_word, {6'h21, 10'd0, 6'h02});
      en = 1'b1; idle(200);
      finish_run();
   end
endmodule